// File: doc/BRIEF.md
# Reset Boot Vector Selector

After every reset this block works out the address at which the processor core begins fetching. It issues a single read of the flash signature byte, which lives in the byte just below the lock byte at the top of an 8 KB flash made of 16 pages of 512 bytes. The byte comes back over a synchronous read port with one cycle of latency. If the byte holds the magic value 0xA5, a bootloader is installed and the start address is the base of the last flash page (0x1E00). Any other value selects the normal reset vector 0x0000.

The core stays held until the block raises its start strobe. That strobe lasts a single cycle, and `start_addr` is valid while it is high. The sequencer has four named states. `ST_IDLE` is entered by reset and is also where the sequencer parks once it has finished. `ST_READ_SIG` drives the read request. `ST_WAIT_DATA` samples the returned byte. `ST_RELEASE` raises the strobe.

The transitions are as follows. Reset forces `ST_IDLE`. The sequencer moves from `ST_IDLE` to `ST_READ_SIG` on the first clock after reset, provided the selection has not yet been served. `ST_READ_SIG` always moves to `ST_WAIT_DATA`, which always moves to `ST_RELEASE`. `ST_RELEASE` returns to `ST_IDLE` and marks the selection as served. A served sequencer remains in `ST_IDLE` until the next reset.

Top module: `boot_vector_sel`

## Requirements
- R1: While `rst_n` is low, `start_valid` and `flash_rd` are both 0.
- R2: Exactly one flash read is issued after reset. It takes place in the second cycle after `rst_n` rises, with `flash_addr` = 0x1FFE (the byte directly below the lock byte at 0x1FFF).
- R3: The signature is taken from `flash_rdata` in the single cycle that follows the read request, which accounts for the one-cycle read latency.
- R4: When the sampled signature equals 0xA5, `start_addr` is 0x1E00 while `start_valid` is high.
- R5: When the sampled signature is any value other than 0xA5, `start_addr` is 0x0000 while `start_valid` is high.
- R6: `start_valid` is high for exactly one cycle, two cycles after the read cycle.
- R7: Once the strobe has been given, no further read or strobe occurs until the next reset, and `start_addr` holds its value.
- R8: Every reset runs the selection again. A reset during the sequence aborts it without a strobe.
- R9: `flash_rdata` has no effect on the selection in any cycle other than the sample cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset from any reset source |
| flash_rd | output | 1 | Flash read request |
| flash_addr | output | 13 | Flash byte address |
| flash_rdata | input | 8 | Flash read data, valid one cycle after the request |
| start_addr | output | 13 | Selected start address |
| start_valid | output | 1 | One-cycle strobe that releases the core |

## Verification
Two situations are hard to reach from the ports. The first is a reset that lands partway through the sequence. The stimulus releases reset and pulls it low again once the read request is seen, then confirms that no strobe appears. The second is flash data that disagrees with the signature outside the sample cycle. The bench flash model returns a chosen "junk" byte for every cycle except the one after a real signature read, and several table rows set that junk to 0xA5 while the true signature is something else, and the reverse. Successive table rows also run back-to-back resets with different signatures, which shows that the decision is remade each time.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_SIG  = 2'd1,
        ST_WAIT_DATA = 2'd2,
        ST_RELEASE   = 2'd3
    } boot_state_t;

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic rd_req,
    output logic sample_en,
    output logic release_stb
);

    boot_state_t state_q, state_d;
    logic        served_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            served_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RELEASE) served_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = served_q ? ST_IDLE : ST_READ_SIG;
            ST_READ_SIG:  state_d = ST_WAIT_DATA;
            ST_WAIT_DATA: state_d = ST_RELEASE;
            ST_RELEASE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req      = 1'b0;
        sample_en   = 1'b0;
        release_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_READ_SIG:  rd_req      = 1'b1;
            ST_WAIT_DATA: sample_en   = 1'b1;
            ST_RELEASE:   release_stb = 1'b1;
            default:      ;
        endcase
    end

    // R6
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_stb |=> !release_stb);

    // R6
    strobe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ##1 release_stb);

    // R7
    served_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        served_q |-> (!rd_req && !release_stb));

endmodule

// File: rtl/boot_sig_match.sv
module boot_sig_match #(
    parameter int unsigned         DATA_W    = 8,
    parameter logic [DATA_W-1:0]   SIG_VALUE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] rdata,
    output logic              boot_present
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_present <= 1'b0;
        end else if (sample_en) begin
            boot_present <= (rdata == SIG_VALUE);
        end
    end

    // R9
    data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(boot_present));

endmodule

// File: rtl/boot_vector_sel.sv
module boot_vector_sel #(
    parameter int unsigned PAGE_BYTES = 512,
    parameter int unsigned PAGES      = 16,
    parameter int unsigned DATA_W     = 8,
    parameter logic [7:0]  SIG_VALUE  = 8'hA5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    output logic                                  flash_rd,
    output logic [$clog2(PAGE_BYTES*PAGES)-1:0]   flash_addr,
    input  logic [DATA_W-1:0]                     flash_rdata,
    output logic [$clog2(PAGE_BYTES*PAGES)-1:0]   start_addr,
    output logic                                  start_valid
);

    localparam int unsigned FLASH_BYTES = PAGE_BYTES * PAGES;
    localparam int unsigned ADDR_W      = $clog2(FLASH_BYTES);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(FLASH_BYTES - 1);
    localparam logic [ADDR_W-1:0] SIG_ADDR  = LOCK_ADDR - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] BOOT_VEC  = ADDR_W'(FLASH_BYTES - PAGE_BYTES);
    localparam logic [ADDR_W-1:0] RST_VEC   = '0;

    logic sample_en;
    logic boot_present;

    boot_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (flash_rd),
        .sample_en   (sample_en),
        .release_stb (start_valid)
    );

    boot_sig_match #(
        .DATA_W    (DATA_W),
        .SIG_VALUE (DATA_W'(SIG_VALUE))
    ) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_en    (sample_en),
        .rdata        (flash_rdata),
        .boot_present (boot_present)
    );

    assign flash_addr = SIG_ADDR;
    assign start_addr = boot_present ? BOOT_VEC : RST_VEC;

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!start_valid && !flash_rd);
        end
    end

    // R2
    read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |-> (flash_addr == SIG_ADDR));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_valid) |-> $stable(start_addr));

endmodule

// File: tb/sim_boot_vector_sel.sv
module sim_boot_vector_sel;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 8;
    localparam logic [12:0] SIG_A = 13'h1FFE;
    localparam logic [12:0] BOOT  = 13'h1E00;

    localparam logic [7:0]  V_SIG  [NVEC] = '{8'hA5, 8'h00, 8'hA4, 8'h5A, 8'hFF, 8'hA5, 8'h25, 8'hA5};
    localparam logic [7:0]  V_JUNK [NVEC] = '{8'h00, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h5A, 8'hA5, 8'hFF};
    localparam logic [12:0] V_EXP  [NVEC] = '{13'h1E00, 13'h0, 13'h0, 13'h0, 13'h0, 13'h1E00, 13'h0, 13'h1E00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_rd;
    logic [12:0] flash_addr;
    logic [7:0]  flash_rdata = 8'h00;
    logic [12:0] start_addr;
    logic        start_valid;

    logic [7:0] sig_v  = 8'h00;
    logic [7:0] junk_v = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // flash model: one-cycle latency, real byte only for a signature read
    always @(posedge clk) begin
        flash_rdata <= (flash_rd && flash_addr == SIG_A) ? sig_v : junk_v;
    end

    boot_vector_sel u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .flash_rd    (flash_rd),
        .flash_addr  (flash_addr),
        .flash_rdata (flash_rdata),
        .start_addr  (start_addr),
        .start_valid (start_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", {30'b0, start_valid, flash_rd}, 32'h0);
        rst_n = 1'b1;
    endtask

    // runs one full selection; rst_n released at a negedge
    task automatic run_boot(input logic [7:0] s, input logic [7:0] j, input logic [12:0] exp);
        sig_v  = s;
        junk_v = j;
        do_reset();
        @(negedge clk); // ST_IDLE -> ST_READ_SIG
        check("R2", {31'b0, flash_rd}, 32'h1);
        check("R2", {19'b0, flash_addr}, {19'b0, SIG_A});
        @(negedge clk); // ST_WAIT_DATA
        check("R6", {31'b0, start_valid}, 32'h0);
        check("R3", {31'b0, flash_rd}, 32'h0);
        @(negedge clk); // ST_RELEASE
        check("R6", {31'b0, start_valid}, 32'h1);
        check((exp == BOOT) ? "R4" : "R5", {19'b0, start_addr}, {19'b0, exp});
        @(negedge clk);
        check("R6", {31'b0, start_valid}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R7", {30'b0, start_valid, flash_rd}, 32'h0);
            check("R7", {19'b0, start_addr}, {19'b0, exp});
        end
    endtask

    initial begin
        // table walk: back-to-back resets with differing signatures (R8, R9)
        for (int i = 0; i < NVEC; i++) begin
            run_boot(V_SIG[i], V_JUNK[i], V_EXP[i]);
        end

        // R8: reset partway through aborts without a strobe
        sig_v  = 8'hA5;
        junk_v = 8'hA5;
        do_reset();
        @(negedge clk);
        check("R8", {31'b0, flash_rd}, 32'h1);
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8", {31'b0, start_valid}, 32'h0);
        end
        // R8: the next reset makes a fresh decision
        run_boot(8'h3C, 8'hA5, 13'h0000);
        run_boot(8'hA5, 8'h00, BOOT);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule